// File: doc/BRIEF.md
# Constant-Time Backtrack and Perfect-Hash Node Lookup

This unit serves a stackless tree walker. It takes the key of the current node and the trail of postponed levels, and in one step it finds the node that the walk returns to. It counts the trailing zeros of the trail and drops that many levels from both the key and the trail. It then flips the lowest bit of each result, which moves the walk to the sibling on that level.

The new key is turned into a node address through a two-level perfect hash. First the unit reads a displacement word, indexed by the low bits of the key, from an external table. If the displacement word has its sign bit set, the word itself encodes the address and the lookup ends there. Otherwise the key and the displacement are added and the sum is reduced modulo the hash size H. The result indexes a second external table, which returns the address.

A request is taken when the unit is idle. Later the unit raises a one-cycle response strobe that carries the new key, the new trail, the address and an error flag.

Top module: `bt_hash_unit`

## Requirements
- R1: After reset `req_ready_o` is 1 and `rsp_valid_o`, `disp_req_o` and `tbl_req_o` are 0. A request is taken only when `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 from the cycle after acceptance until the response has been given.
- R2: For a nonzero trail with n trailing zeros, the response carries trail `(trail >> n) ^ 1` and key `(key >> n) ^ 1`.
- R3: A request with a nonzero trail makes exactly one displacement read. Its index is the low DISP_AW bits of the new key, so the table depth is D = 2^DISP_AW.
- R4: If the displacement word has bit 31 set and is below 0xC0000000 unsigned, the address is the word minus 0x80000000. No hash-table read is made, and the response follows one cycle after the data arrives.
- R5: If the displacement word is 0xC0000000 or above, the address is the word unchanged, and no hash-table read is made.
- R6: If the displacement word has bit 31 clear, exactly one hash-table read is made at index (new key + word) mod H. The sum uses the full width, with no wrap at 32 bits. The address is the word that this read returns.
- R7: H is taken from `hash_size_i` at acceptance. It must be nonzero, odd and below 2^HASH_AW. Changing the input later has no effect on a request already in flight.
- R8: The modulo reduction takes a fixed time. The hash-table request appears exactly KEY_W+3 cycles after the cycle in which the displacement data is presented.
- R9: `rsp_valid_o` is a single-cycle pulse. It is raised only after the last memory read of the request has returned.
- R10: A zero trail is an error. The response comes in the cycle after acceptance with `rsp_err_o`=1, the input key and trail echoed back, and address 0. No memory read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Unit idle, request may be taken |
| key_i | input | KEY_W | Key of the current node |
| trail_i | input | KEY_W | Postponed-level trail |
| hash_size_i | input | HASH_AW | Hash table size H |
| disp_req_o | output | 1 | Displacement read request (one cycle) |
| disp_addr_o | output | DISP_AW | Displacement read index |
| disp_rvalid_i | input | 1 | Displacement data valid |
| disp_rdata_i | input | 32 | Displacement word |
| tbl_req_o | output | 1 | Hash table read request (one cycle) |
| tbl_addr_o | output | HASH_AW | Hash table read index |
| tbl_rvalid_i | input | 1 | Hash table data valid |
| tbl_rdata_i | input | 32 | Node address from hash table |
| rsp_valid_o | output | 1 | Response strobe (one cycle) |
| rsp_key_o | output | KEY_W | Backtracked key |
| rsp_trail_o | output | KEY_W | Backtracked trail |
| rsp_addr_o | output | 32 | Resolved node address |
| rsp_err_o | output | 1 | Zero-trail error |

## Verification
The hardest case to reach is a hash-path lookup whose key-plus-displacement sum exceeds 32 bits. A truncated adder would give a wrong index without any other visible symptom. The stimulus steers there by choosing a key whose backtracked low bits select a displacement entry that holds a large positive word, while the key's upper bits are all ones. The exact boundary words 0xBFFFFFFF and 0xC0000000 are placed in entries that specific keys reach. Memory latency is varied, so that the fixed reduction time is measured independently of read delay.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] SHORT_LIM  = 32'hC000_0000;
  localparam logic [WORD_W-1:0] SHORT_BIAS = 32'h8000_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_RED, ST_TREQ, ST_TWAIT, ST_DONE
  } bt_state_t;
endpackage

// File: rtl/bt_backtrack_step.sv
module bt_backtrack_step #(
  parameter int KEY_W = 32
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] trail_i,
  output logic [KEY_W-1:0] key_o,
  output logic [KEY_W-1:0] trail_o,
  output logic             none_o
);
  localparam int CNT_W = $clog2(KEY_W);

  logic [CNT_W-1:0] tz;

  // lowest set bit wins
  always_comb begin
    tz = '0;
    for (int i = KEY_W-1; i >= 0; i--) begin
      if (trail_i[i]) tz = CNT_W'(i);
    end
  end

  assign none_o  = (trail_i == '0);
  assign key_o   = (key_i >> tz) ^ KEY_W'(1);
  assign trail_o = (trail_i >> tz) ^ KEY_W'(1);
endmodule

// File: rtl/bt_disp_decode.sv
module bt_disp_decode
  import bt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              short_o,
  output logic [WORD_W-1:0] addr_o
);
  assign short_o = word_i[WORD_W-1];
  assign addr_o  = (word_i < SHORT_LIM) ? (word_i - SHORT_BIAS) : word_i;
endmodule

// File: rtl/bt_mod_reducer.sv
module bt_mod_reducer #(
  parameter int SUM_W = 33,
  parameter int H_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [H_W-1:0]   h_i,
  output logic             done_o,
  output logic [H_W-1:0]   rem_o
);
  localparam int CW = $clog2(SUM_W+1);

  logic [SUM_W-1:0] sh_q;
  logic [H_W-1:0]   rem_q, rem_d;
  logic [H_W:0]     trial;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q;

  // restoring remainder, one dividend bit per cycle
  always_comb begin
    trial = {rem_q, sh_q[SUM_W-1]};
    if (trial >= {1'b0, h_i}) rem_d = H_W'(trial - {1'b0, h_i});
    else                      rem_d = trial[H_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q   <= sum_i;
        rem_q  <= '0;
        cnt_q  <= CW'(SUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q  <= sh_q << 1;
        rem_q <= rem_d;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;

  // independent window counter
  logic [CW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (start_i)  run_q <= '0;
    else if (busy_q)   run_q <= run_q + 1'b1;
  end

  assert_rem_below_h_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rem_o < h_i));
  assert_run_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (run_q < CW'(SUM_W)));
  assert_start_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/bt_hash_unit.sv
module bt_hash_unit
  import bt_pkg::*;
#(
  parameter int KEY_W   = 32,
  parameter int DISP_AW = 6,
  parameter int HASH_AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [KEY_W-1:0]   trail_i,
  input  logic [HASH_AW-1:0] hash_size_i,
  output logic               disp_req_o,
  output logic [DISP_AW-1:0] disp_addr_o,
  input  logic               disp_rvalid_i,
  input  logic [WORD_W-1:0]  disp_rdata_i,
  output logic               tbl_req_o,
  output logic [HASH_AW-1:0] tbl_addr_o,
  input  logic               tbl_rvalid_i,
  input  logic [WORD_W-1:0]  tbl_rdata_i,
  output logic               rsp_valid_o,
  output logic [KEY_W-1:0]   rsp_key_o,
  output logic [KEY_W-1:0]   rsp_trail_o,
  output logic [WORD_W-1:0]  rsp_addr_o,
  output logic               rsp_err_o
);
  localparam int SUM_W = ((KEY_W > WORD_W-1) ? KEY_W : WORD_W-1) + 1;

  bt_state_t          st_q, st_d;
  logic [KEY_W-1:0]   key_q, trail_q, nk, nt;
  logic [WORD_W-1:0]  addr_q, short_addr;
  logic [HASH_AW-1:0] h_q, rem;
  logic               err_q, none, is_short, accept, red_start, red_done;
  logic [SUM_W-1:0]   sum;

  bt_backtrack_step #(.KEY_W(KEY_W)) i_step (
    .key_i(key_i), .trail_i(trail_i), .key_o(nk), .trail_o(nt), .none_o(none)
  );

  bt_disp_decode i_dec (
    .word_i(disp_rdata_i), .short_o(is_short), .addr_o(short_addr)
  );

  assign sum       = SUM_W'(key_q) + SUM_W'(disp_rdata_i[WORD_W-2:0]);
  assign red_start = (st_q == ST_DWAIT) && disp_rvalid_i && !is_short;

  bt_mod_reducer #(.SUM_W(SUM_W), .H_W(HASH_AW)) i_red (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(red_start), .sum_i(sum),
    .h_i(h_q), .done_o(red_done), .rem_o(rem)
  );

  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = none ? ST_DONE : ST_DREQ;
      ST_DREQ:  st_d = ST_DWAIT;
      ST_DWAIT: if (disp_rvalid_i) st_d = is_short ? ST_DONE : ST_RED;
      ST_RED:   if (red_done) st_d = ST_TREQ;
      ST_TREQ:  st_d = ST_TWAIT;
      ST_TWAIT: if (tbl_rvalid_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      key_q   <= '0;
      trail_q <= '0;
      addr_q  <= '0;
      h_q     <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        h_q <= hash_size_i;
        if (none) begin
          key_q   <= key_i;
          trail_q <= trail_i;
          addr_q  <= '0;
          err_q   <= 1'b1;
        end else begin
          key_q   <= nk;
          trail_q <= nt;
          err_q   <= 1'b0;
        end
      end
      if ((st_q == ST_DWAIT) && disp_rvalid_i && is_short) addr_q <= short_addr;
      if ((st_q == ST_TWAIT) && tbl_rvalid_i)              addr_q <= tbl_rdata_i;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign disp_req_o  = (st_q == ST_DREQ);
  assign disp_addr_o = key_q[DISP_AW-1:0];
  assign tbl_req_o   = (st_q == ST_TREQ);
  assign tbl_addr_o  = rem;
  assign rsp_valid_o = (st_q == ST_DONE);
  assign rsp_key_o   = key_q;
  assign rsp_trail_o = trail_q;
  assign rsp_addr_o  = addr_q;
  assign rsp_err_o   = err_q;

  assert_busy_after_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_rsp_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_zero_trail_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (trail_i == '0)) |=> (rsp_valid_o && rsp_err_o));
  assert_short_direct_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DWAIT) && disp_rvalid_i && disp_rdata_i[WORD_W-1]) |=> (rsp_valid_o && !rsp_err_o));
  assert_tbl_after_red_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_req_o |-> $past(red_done));
endmodule

// File: tb/test_bt_hash_unit.sv
module test_bt_hash_unit;
  localparam int KEY_W = 32, DISP_AW = 6, HASH_AW = 8;
  localparam int DN = 1 << DISP_AW, HN = 1 << HASH_AW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [KEY_W-1:0] key_i = '0, trail_i = '0;
  logic [HASH_AW-1:0] hash_size_i = '0;
  logic disp_req_o, tbl_req_o, rsp_valid_o, rsp_err_o;
  logic [DISP_AW-1:0] disp_addr_o;
  logic [HASH_AW-1:0] tbl_addr_o;
  logic d_rvalid = 1'b0, t_rvalid = 1'b0;
  logic [31:0] d_rdata = '0, t_rdata = '0, rsp_addr_o;
  logic [KEY_W-1:0] rsp_key_o, rsp_trail_o;

  always #10 clk_i = ~clk_i;

  bt_hash_unit #(.KEY_W(KEY_W), .DISP_AW(DISP_AW), .HASH_AW(HASH_AW)) i_bt_hash_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .key_i(key_i), .trail_i(trail_i), .hash_size_i(hash_size_i),
    .disp_req_o(disp_req_o), .disp_addr_o(disp_addr_o), .disp_rvalid_i(d_rvalid),
    .disp_rdata_i(d_rdata), .tbl_req_o(tbl_req_o), .tbl_addr_o(tbl_addr_o),
    .tbl_rvalid_i(t_rvalid), .tbl_rdata_i(t_rdata), .rsp_valid_o(rsp_valid_o),
    .rsp_key_o(rsp_key_o), .rsp_trail_o(rsp_trail_o), .rsp_addr_o(rsp_addr_o),
    .rsp_err_o(rsp_err_o)
  );

  logic [31:0] disp_mem [DN];
  logic [31:0] hash_mem [HN];
  int n_vec = 0, n_bad = 0, mem_lat = 0;
  int disp_reads = 0, tbl_reads = 0, cyc = 0, rv_stamp = 0, tq_stamp = 0;
  logic [DISP_AW-1:0] last_daddr = '0;
  logic [HASH_AW-1:0] last_taddr = '0;
  bit expecting = 0;

  // memory models with programmable latency
  logic d_pend = 1'b0, t_pend = 1'b0;
  int d_cnt = 0, t_cnt = 0;
  logic [DISP_AW-1:0] d_a = '0;
  logic [HASH_AW-1:0] t_a = '0;
  always @(posedge clk_i) begin
    d_rvalid <= 1'b0;
    t_rvalid <= 1'b0;
    if (disp_req_o) begin
      d_pend <= 1'b1; d_cnt <= mem_lat; d_a <= disp_addr_o;
    end else if (d_pend) begin
      if (d_cnt == 0) begin d_rvalid <= 1'b1; d_rdata <= disp_mem[d_a]; d_pend <= 1'b0; end
      else d_cnt <= d_cnt - 1;
    end
    if (tbl_req_o) begin
      t_pend <= 1'b1; t_cnt <= mem_lat; t_a <= tbl_addr_o;
    end else if (t_pend) begin
      if (t_cnt == 0) begin t_rvalid <= 1'b1; t_rdata <= hash_mem[t_a]; t_pend <= 1'b0; end
      else t_cnt <= t_cnt - 1;
    end
  end
  always @(posedge clk_i) begin
    if (disp_req_o) begin disp_reads++; last_daddr = disp_addr_o; end
    if (tbl_req_o)  begin tbl_reads++;  last_taddr = tbl_addr_o;  end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every-clock monitor
  always @(negedge clk_i) begin
    cyc++;
    if (d_rvalid)  rv_stamp = cyc;
    if (tbl_req_o) tq_stamp = cyc;
    if (rsp_valid_o && !expecting) chk(0, "R9", "unexpected response", 1, 0);
  end

  task automatic do_req(input logic [31:0] key, input logic [31:0] trail,
                        input int h, input int lat);
    logic [31:0] ek, et, ea, d;
    logic [DISP_AW-1:0] dix;
    bit eerr, hpath;
    int edr, etr, d0, t0, k, n;
    longint s, ti;
    ti = 0; dix = '0; hpath = 0;
    if (trail == 0) begin
      eerr = 1; ek = key; et = trail; ea = 0; edr = 0; etr = 0;
    end else begin
      eerr = 0; n = 0;
      while (!trail[n]) n++;
      ek = (key >> n) ^ 32'd1; et = (trail >> n) ^ 32'd1;
      dix = ek[DISP_AW-1:0]; d = disp_mem[dix]; edr = 1;
      if (d[31]) begin
        ea = (d < 32'hC000_0000) ? d - 32'h8000_0000 : d; etr = 0;
      end else begin
        s = longint'(ek) + longint'(d); ti = s % longint'(h);
        ea = hash_mem[ti]; etr = 1; hpath = 1;
      end
    end
    @(negedge clk_i);
    mem_lat = lat; d0 = disp_reads; t0 = tbl_reads;
    key_i = key; trail_i = trail; hash_size_i = HASH_AW'(h);
    req_valid_i = 1'b1; expecting = 1;
    chk(req_ready_o == 1'b1, "R1", "ready idle", 32'(req_ready_o), 1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    hash_size_i = HASH_AW'(h ^ 2);  // late change must not matter (R7)
    chk(req_ready_o == 1'b0, "R1", "ready busy", 32'(req_ready_o), 0);
    k = 0;
    while (!rsp_valid_o && k < 400) begin @(negedge clk_i); k++; end
    chk(rsp_valid_o == 1'b1, "R9", "response timeout", 32'(k), 0);
    if (eerr) chk(k == 0, "R10", "error latency", 32'(k), 0);
    chk(rsp_err_o == eerr, eerr ? "R10" : "R2", "err flag", 32'(rsp_err_o), 32'(eerr));
    chk(rsp_key_o == ek, eerr ? "R10" : "R2", "key", rsp_key_o, ek);
    chk(rsp_trail_o == et, eerr ? "R10" : "R2", "trail", rsp_trail_o, et);
    chk(rsp_addr_o == ea, hpath ? "R6" : (eerr ? "R10" : "R4"), "addr", rsp_addr_o, ea);
    chk(disp_reads - d0 == edr, "R3", "disp read count", 32'(disp_reads - d0), 32'(edr));
    if (edr == 1) chk(last_daddr == dix, "R3", "disp index", 32'(last_daddr), 32'(dix));
    chk(tbl_reads - t0 == etr, "R5", "tbl read count", 32'(tbl_reads - t0), 32'(etr));
    if (hpath) begin
      chk(32'(last_taddr) == 32'(ti), "R7", "tbl index", 32'(last_taddr), 32'(ti));
      chk(tq_stamp - rv_stamp == KEY_W + 3, "R8", "reduce latency",
          32'(tq_stamp - rv_stamp), 32'(KEY_W + 3));
    end
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R9", "pulse width", 32'(rsp_valid_o), 0);
    expecting = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "R9", "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int hs [6];
    hs = '{201, 131, 255, 3, 1, 97};
    for (int i = 0; i < DN; i++) begin
      case (i % 4)
        0:       disp_mem[i] = 32'h8000_0000 + 32'(i) * 32'h10;
        1:       disp_mem[i] = 32'hC000_0000 + 32'(i) * 3;
        default: disp_mem[i] = 32'(i) * 13 + 7;
      endcase
    end
    disp_mem[4] = 32'hBFFF_FFFF;
    disp_mem[5] = 32'hC000_0000;
    disp_mem[2] = 32'h7FFF_FFF0;
    for (int i = 0; i < HN; i++) hash_mem[i] = 32'h0010_0000 + 32'(i) * 32'h105;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", "reset ready", 32'(req_ready_o), 1);
    chk(rsp_valid_o == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid_o), 0);
    chk(disp_req_o == 1'b0 && tbl_req_o == 1'b0, "R1", "reset mem req",
        32'({disp_req_o, tbl_req_o}), 0);

    do_req(32'd45, 32'd0, 201, 1);                   // R10 zero trail
    do_req(32'd22, 32'b00100, 131, 0);               // R4 boundary 0xBFFFFFFF
    do_req(32'd8, 32'd2, 131, 2);                    // R5 boundary 0xC0000000
    do_req(32'hFFFF_FF83, 32'd1, 255, 3);            // R6 sum beyond 32 bits
    do_req(32'h8000_0001, 32'h8000_0000, 97, 1);     // R2 top trail bit only
    do_req(32'hFFFF_FF83, 32'd1, 1, 0);              // R7 H = 1
    for (int i = 0; i < 60; i++) begin
      logic [31:0] kk, tt;
      kk = $urandom;
      tt = $urandom;
      if (i % 7 == 0) tt = 0;
      else if (i % 3 == 0) tt = tt & 32'hFFFF_0000;
      do_req(kk, tt, hs[i % 6], i % 4);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule